// File: doc/BRIEF.md
# Raster Display Timing Generator

This block sequences the horizontal and vertical timing of a raster display. Both axes step through four phases in a fixed order: sync, back porch, active data and front porch. Each phase has its own programmable length. The horizontal axis advances once per pixel clock. The vertical axis advances once per completed line. While both axes are in their active phase, the block takes one pixel from an upstream pixel FIFO on every clock and drives it onto the output pixel bus with the data-enable strobe.

When the FIFO is empty at an active pixel, the block flags an underrun. For the rest of that frame it stops taking pixels and repeats the last pixel it sent, and it asks the fetch engine to stop. The next frame's vertical sync clears the condition. Each strobe has its own polarity control. The block also emits single-cycle events: vertical-sync start and underrun for an interrupt block, and frame start for the fetch engine. One enable input gates the whole generator.

Top module: `disp_timing_gen`

## Requirements
- R1: A length field of value N makes its phase last N+1 clocks. The horizontal phases run in the order sync, back porch, active, front porch. The raw hsync is high during horizontal sync. Every output is registered, so the output for timing position k appears after the clock edge that leaves position k.
- R2: The vertical axis advances by one line each time the horizontal front porch ends. It runs the same phase order in lines, with N+1 lines per phase. The raw vsync is high for the whole vertical sync phase.
- R3: de_out is high exactly when both axes are in their active phase. On each such clock with data in the FIFO, fifo_pop is high for one clock. The popped word appears on pix_out together with de_out, and the words come out in FIFO order.
- R4: Each bit of pol_sel inverts one output when set. Bit 0 inverts vsync_out, bit 1 inverts hsync_out, bit 2 inverts de_out, and bit 3 inverts every bit of pix_out. Bit 4 is passed to pclk_invert to flip the pixel clock edge.
- R5: An active pixel that finds fifo_empty high produces a one-clock underrun_irq pulse aligned with that pixel. fetch_halt rises at the same time.
- R6: Once an underrun has occurred, every later active pixel of the frame shows the last word sent in this frame, or zero if none was sent. No further pops occur in the frame, even if the FIFO refills.
- R7: The first clock of vertical sync produces a one-clock vsync_irq pulse. The same clock clears the underrun state, including fetch_halt, and clears the held pixel to zero.
- R8: frame_start pulses for one clock, aligned with the last clock of the vertical sync phase.
- R9: While en is low, both counters return to the start of vertical sync. The strobes sit at their inactive levels, and no pops, events or fetch_halt occur. Raising en starts a frame at the first clock of vertical sync.
- R10: Outside the active region the raw pixel bus is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Generator enable |
| pol_sel | input | 5 | Per-output polarity inversion bits |
| h_sync_len | input | CW | Horizontal sync length minus one |
| h_back_len | input | CW | Horizontal back porch length minus one |
| h_act_len | input | CW | Horizontal active length minus one |
| h_front_len | input | CW | Horizontal front porch length minus one |
| v_sync_len | input | CW | Vertical sync length minus one, in lines |
| v_back_len | input | CW | Vertical back porch length minus one, in lines |
| v_act_len | input | CW | Vertical active length minus one, in lines |
| v_front_len | input | CW | Vertical front porch length minus one, in lines |
| fifo_empty | input | 1 | Pixel FIFO has no data |
| fifo_data | input | PW | Pixel word at the FIFO head |
| fifo_pop | output | 1 | Take the FIFO head this clock |
| hsync_out | output | 1 | Horizontal sync strobe |
| vsync_out | output | 1 | Vertical sync strobe |
| de_out | output | 1 | Data-enable strobe |
| pix_out | output | PW | Output pixel bus |
| pclk_invert | output | 1 | Pixel clock edge inversion select |
| vsync_irq | output | 1 | Vertical sync start event |
| underrun_irq | output | 1 | Underrun event |
| frame_start | output | 1 | Frame fetch start pulse |
| fetch_halt | output | 1 | Underrun latched; fetch should stop |

## Verification
The bench starves the FIFO partway through a frame and then refills it before the frame ends. A design that resumed popping after the refill would show fresh words instead of the repeated one, and the FIFO count would drift. A second run starves an entire frame that follows a good one. A design that kept the previous frame's held word through vertical sync would show that word where zero is expected, and a design that never cleared the underrun state would stay halted in the next frame. Other runs invert every strobe, and drop the enable in the middle of an active line. These catch polarity bits wired to the wrong output and a generator that keeps popping or raising events after it is disabled.

// File: rtl/disp_timing_pkg.sv
package disp_timing_pkg;
   typedef enum logic [1:0] {
      PH_SYNC  = 2'd0,
      PH_BACK  = 2'd1,
      PH_ACT   = 2'd2,
      PH_FRONT = 2'd3
   } phase_e;

   localparam int POL_BITS = 5;
   localparam int POL_VS   = 0;
   localparam int POL_HS   = 1;
   localparam int POL_DE   = 2;
   localparam int POL_PIX  = 3;
   localparam int POL_CLK  = 4;
endpackage

// File: rtl/dtg_axis_counter.sv
module dtg_axis_counter
   import disp_timing_pkg::*;
#(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   input  logic [CW-1:0] len_sync,
   input  logic [CW-1:0] len_back,
   input  logic [CW-1:0] len_act,
   input  logic [CW-1:0] len_front,
   output phase_e        phase,
   output logic [CW-1:0] count,
   output logic          phase_done,
   output logic          axis_wrap
);
   generate
      if (CW < 2 || CW > 16) begin : g_bad_cw
         $error("dtg_axis_counter: CW must lie in 2..16");
      end
   endgenerate

   logic [CW-1:0] cur_len;
   phase_e        nxt_phase;

   always_comb begin
      case (phase)
         PH_SYNC:  begin cur_len = len_sync;  nxt_phase = PH_BACK;  end
         PH_BACK:  begin cur_len = len_back;  nxt_phase = PH_ACT;   end
         PH_ACT:   begin cur_len = len_act;   nxt_phase = PH_FRONT; end
         default:  begin cur_len = len_front; nxt_phase = PH_SYNC;  end
      endcase
   end

   assign phase_done = (count >= cur_len);
   assign axis_wrap  = phase_done && (phase == PH_FRONT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_SYNC;
         count <= '0;
      end else if (clr) begin
         phase <= PH_SYNC;
         count <= '0;
      end else if (step) begin
         if (phase_done) begin
            phase <= nxt_phase;
            count <= '0;
         end else begin
            count <= count + 1'b1;
         end
      end
   end

   // R1 / R2: every phase entry starts from a zero count
   p_phase_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != $past(phase)) |-> (count == '0));
endmodule

// File: rtl/dtg_pixel_path.sv
module dtg_pixel_path #(
   parameter int PW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          active,
   input  logic          frame_top,
   input  logic          fifo_empty,
   input  logic [PW-1:0] fifo_data,
   output logic          fifo_pop,
   output logic [PW-1:0] pix_sel,
   output logic          underrun_evt,
   output logic          halt_fetch
);
   generate
      if (PW < 1) begin : g_bad_pw
         $error("dtg_pixel_path: PW must be positive");
      end
   endgenerate

   logic [PW-1:0] held_px;

   assign fifo_pop     = active && !halt_fetch && !fifo_empty;
   assign underrun_evt = active && !halt_fetch && fifo_empty;
   assign pix_sel      = fifo_pop ? fifo_data : held_px;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_px    <= '0;
         halt_fetch <= 1'b0;
      end else if (!en || frame_top) begin
         held_px    <= '0;
         halt_fetch <= 1'b0;
      end else begin
         if (fifo_pop)     held_px    <= fifo_data;
         if (underrun_evt) halt_fetch <= 1'b1;
      end
   end

   // R6: while halted, the held pixel cannot change inside the frame
   p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(halt_fetch) && halt_fetch) |-> $stable(held_px));
endmodule

// File: rtl/dtg_out_stage.sv
module dtg_out_stage
   import disp_timing_pkg::*;
#(
   parameter int PW         = 24,
   parameter bit BLANK_ZERO = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [POL_BITS-1:0] pol,
   input  logic                hs_raw,
   input  logic                vs_raw,
   input  logic                de_raw,
   input  logic [PW-1:0]       pix_sel,
   input  logic                vs_evt,
   input  logic                ur_evt,
   input  logic                fs_evt,
   output logic                hsync_out,
   output logic                vsync_out,
   output logic                de_out,
   output logic [PW-1:0]       pix_out,
   output logic                pclk_invert,
   output logic                vsync_irq,
   output logic                underrun_irq,
   output logic                frame_start
);
   logic [PW-1:0] pix_raw;

   generate
      if (BLANK_ZERO) begin : g_blank
         assign pix_raw = de_raw ? pix_sel : '0;
      end else begin : g_hold
         assign pix_raw = pix_sel;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hsync_out    <= 1'b0;
         vsync_out    <= 1'b0;
         de_out       <= 1'b0;
         pix_out      <= '0;
         pclk_invert  <= 1'b0;
         vsync_irq    <= 1'b0;
         underrun_irq <= 1'b0;
         frame_start  <= 1'b0;
      end else begin
         hsync_out    <= hs_raw ^ pol[POL_HS];
         vsync_out    <= vs_raw ^ pol[POL_VS];
         de_out       <= de_raw ^ pol[POL_DE];
         pix_out      <= pix_raw ^ {PW{pol[POL_PIX]}};
         pclk_invert  <= pol[POL_CLK];
         vsync_irq    <= vs_evt;
         underrun_irq <= ur_evt;
         frame_start  <= fs_evt;
      end
   end
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
   import disp_timing_pkg::*;
#(
   parameter int CW         = 12,
   parameter int PW         = 24,
   parameter bit BLANK_ZERO = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic [POL_BITS-1:0] pol_sel,
   input  logic [CW-1:0]       h_sync_len,
   input  logic [CW-1:0]       h_back_len,
   input  logic [CW-1:0]       h_act_len,
   input  logic [CW-1:0]       h_front_len,
   input  logic [CW-1:0]       v_sync_len,
   input  logic [CW-1:0]       v_back_len,
   input  logic [CW-1:0]       v_act_len,
   input  logic [CW-1:0]       v_front_len,
   input  logic                fifo_empty,
   input  logic [PW-1:0]       fifo_data,
   output logic                fifo_pop,
   output logic                hsync_out,
   output logic                vsync_out,
   output logic                de_out,
   output logic [PW-1:0]       pix_out,
   output logic                pclk_invert,
   output logic                vsync_irq,
   output logic                underrun_irq,
   output logic                frame_start,
   output logic                fetch_halt
);
   phase_e        h_phase, v_phase;
   logic [CW-1:0] h_count, v_count;
   logic          h_done, h_wrap, v_done, v_wrap;
   logic          active, frame_top, fs_evt, ur_evt;
   logic [PW-1:0] pix_sel;

   dtg_axis_counter #(.CW(CW)) u_hcnt (
      .clk(clk), .rst_n(rst_n), .clr(!en), .step(1'b1),
      .len_sync(h_sync_len), .len_back(h_back_len),
      .len_act(h_act_len), .len_front(h_front_len),
      .phase(h_phase), .count(h_count),
      .phase_done(h_done), .axis_wrap(h_wrap)
   );

   dtg_axis_counter #(.CW(CW)) u_vcnt (
      .clk(clk), .rst_n(rst_n), .clr(!en), .step(h_wrap),
      .len_sync(v_sync_len), .len_back(v_back_len),
      .len_act(v_act_len), .len_front(v_front_len),
      .phase(v_phase), .count(v_count),
      .phase_done(v_done), .axis_wrap(v_wrap)
   );

   assign active    = en && (h_phase == PH_ACT) && (v_phase == PH_ACT);
   assign frame_top = en && (v_phase == PH_SYNC) && (v_count == '0)
                         && (h_phase == PH_SYNC) && (h_count == '0);
   assign fs_evt    = en && (v_phase == PH_SYNC) && v_done && h_wrap;

   dtg_pixel_path #(.PW(PW)) u_pix (
      .clk(clk), .rst_n(rst_n), .en(en), .active(active),
      .frame_top(frame_top), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
      .fifo_pop(fifo_pop), .pix_sel(pix_sel), .underrun_evt(ur_evt),
      .halt_fetch(fetch_halt)
   );

   dtg_out_stage #(.PW(PW), .BLANK_ZERO(BLANK_ZERO)) u_out (
      .clk(clk), .rst_n(rst_n), .pol(pol_sel),
      .hs_raw(en && (h_phase == PH_SYNC)),
      .vs_raw(en && (v_phase == PH_SYNC)),
      .de_raw(active), .pix_sel(pix_sel),
      .vs_evt(frame_top), .ur_evt(ur_evt), .fs_evt(fs_evt),
      .hsync_out(hsync_out), .vsync_out(vsync_out), .de_out(de_out),
      .pix_out(pix_out), .pclk_invert(pclk_invert),
      .vsync_irq(vsync_irq), .underrun_irq(underrun_irq),
      .frame_start(frame_start)
   );

   // R3: pops only happen inside the active region of both axes
   p_pop_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> (h_phase == PH_ACT && v_phase == PH_ACT));
   // R5: the underrun event and the fetch halt appear together
   p_ur_halts_r5: assert property (@(posedge clk) disable iff (!rst_n)
      underrun_irq |-> fetch_halt);
   p_halt_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fetch_halt) |-> underrun_irq);
   // R7: vertical sync start leaves no underrun state behind
   p_vs_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      vsync_irq |-> !fetch_halt);
   // R8: frame start is a single-clock pulse
   p_fs_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start);
   // R9: nothing is signalled while disabled
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!vsync_irq && !underrun_irq && !frame_start && !fetch_halt));
endmodule

// File: tb/sim_disp_timing_gen.sv
`timescale 1ns/1ps
module sim_disp_timing_gen;
   localparam int FRAME = 54;   // 9 clocks x 6 lines

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [4:0]  pol = 5'd0;
   int          lim = 1000000;
   logic [23:0] nv;
   logic        fifo_empty, fifo_pop;
   logic        hsync_out, vsync_out, de_out, pclk_invert;
   logic        vsync_irq, underrun_irq, frame_start, fetch_halt;
   logic [23:0] pix_out;
   int          n_chk = 0;
   int          n_err = 0;

   always #4 clk = ~clk;

   // simple FIFO source: words count up from 1, empty once the count passes lim
   always @(posedge clk or negedge rst_n)
      if (!rst_n) nv <= 24'd1;
      else if (fifo_pop) nv <= nv + 24'd1;
   assign fifo_empty = (int'(nv) > lim);

   disp_timing_gen u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .pol_sel(pol),
      .h_sync_len(12'd1), .h_back_len(12'd0), .h_act_len(12'd3), .h_front_len(12'd1),
      .v_sync_len(12'd1), .v_back_len(12'd0), .v_act_len(12'd1), .v_front_len(12'd0),
      .fifo_empty(fifo_empty), .fifo_data(nv), .fifo_pop(fifo_pop),
      .hsync_out(hsync_out), .vsync_out(vsync_out), .de_out(de_out),
      .pix_out(pix_out), .pclk_invert(pclk_invert), .vsync_irq(vsync_irq),
      .underrun_irq(underrun_irq), .frame_start(frame_start), .fetch_halt(fetch_halt)
   );

   task automatic chk(input string tag, input string what, input longint got, input longint exp);
      n_chk++;
      if (got != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
      end
   endtask

   task automatic idle_levels(input string tag);
      chk(tag, "hsync idle", hsync_out, pol[1]);
      chk(tag, "vsync idle", vsync_out, pol[0]);
      chk(tag, "de idle", de_out, pol[2]);
      chk(tag, "pix idle", pix_out, pol[3] ? 24'hFFFFFF : 24'h0);
      chk(tag, "no vsync irq", vsync_irq, 0);
      chk(tag, "no underrun irq", underrun_irq, 0);
      chk(tag, "no frame start", frame_start, 0);
      chk(tag, "no halt", fetch_halt, 0);
   endtask

   // enable at pos 0 and check every output against the position model
   task automatic run_frames(input int ncyc, input int chg_at, input int chg_lim, input int stop_at);
      int m_nv = int'(nv);
      int m_last = 0;
      bit m_ur = 0;
      string tp = (pol != 5'd0) ? " R4" : "";
      en = 1'b1;
      for (int k = 0; k < ncyc; k++) begin
         int p = k % FRAME;
         int ln = p / 9;
         int x = p % 9;
         bit act, e_ur;
         int e_pix;
         if (k == chg_at) lim = chg_lim;
         if (k == stop_at) begin
            int nv_keep = int'(nv);
            en = 1'b0;
            @(posedge clk); @(negedge clk);
            idle_levels("R9");
            chk("R9", "no pop after disable", int'(nv), nv_keep);
            chk("R9", "pop low while disabled", fifo_pop, 0);
            return;
         end
         @(posedge clk); @(negedge clk);
         if (p == 0) begin m_ur = 0; m_last = 0; end
         act = (ln >= 3) && (ln <= 4) && (x >= 3) && (x <= 6);
         e_ur = 0;
         e_pix = 0;
         if (act) begin
            if (!m_ur && m_nv <= lim) begin
               e_pix = m_nv; m_last = m_nv; m_nv++;
            end else begin
               if (!m_ur) e_ur = 1;
               m_ur = 1;
               e_pix = m_last;
            end
         end
         if (pol[3]) e_pix = e_pix ^ 24'hFFFFFF;
         chk({"R1", tp}, "hsync", hsync_out, (x < 2) ^ pol[1]);
         chk({"R2", tp}, "vsync", vsync_out, (ln < 2) ^ pol[0]);
         chk({"R3", tp}, "de", de_out, act ^ pol[2]);
         chk(act ? (m_ur ? "R6" : "R3") : "R10", "pixel", pix_out, e_pix);
         chk("R6", "pop count", int'(nv), m_nv);
         chk("R5", "underrun irq", underrun_irq, e_ur);
         chk("R5", "fetch halt", fetch_halt, m_ur);
         chk("R7", "vsync irq", vsync_irq, p == 0);
         chk("R8", "frame start", frame_start, p == 17);
         chk({"R4", tp}, "pclk invert", pclk_invert, pol[4]);
      end
      en = 1'b0;
      @(posedge clk); @(negedge clk);
      @(posedge clk); @(negedge clk);
   endtask

   task automatic t_reset();
      #1;
      chk("R9", "reset hsync", hsync_out, 0);
      chk("R9", "reset de", de_out, 0);
      chk("R9", "reset pop", fifo_pop, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      idle_levels("R9");
   endtask

   task automatic t_pol_idle();
      pol = 5'h1F;
      repeat (2) @(negedge clk);
      idle_levels("R4");
      chk("R4", "pclk invert idle", pclk_invert, 1);
      pol = 5'h00;
      repeat (2) @(negedge clk);
      chk("R4", "pclk invert back", pclk_invert, 0);
   endtask

   task automatic t_normal();      // R1 R2 R3 R7 R8 R10
      lim = 1000000;
      run_frames(2 * FRAME, -1, 0, -1);
   endtask

   task automatic t_underrun_mid(); // R5 R6: starve after 5 words, refill at once
      lim = int'(nv) + 4;
      run_frames(2 * FRAME, 41, 1000000, -1);
   endtask

   task automatic t_underrun_full(); // R6 R7: good frame, then an empty frame
      lim = int'(nv) + 7;
      run_frames(3 * FRAME, 100, 1000000, -1);
   endtask

   task automatic t_pol_run();      // R4 while running
      pol = 5'h0F;
      lim = 1000000;
      run_frames(FRAME, -1, 0, -1);
      pol = 5'h00;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_disable();      // R9: drop enable inside the active region
      lim = 1000000;
      run_frames(FRAME, -1, 0, 30);
      repeat (2) @(negedge clk);
      run_frames(FRAME, -1, 0, -1);
   endtask

   initial begin
      t_reset();
      t_pol_idle();
      t_normal();
      t_underrun_mid();
      t_underrun_full();
      t_pol_run();
      t_disable();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(200000 * 8);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule